// File: doc/BRIEF.md
# Immediate Carrying-Add Execution Unit

This unit executes the two immediate carrying-add instructions of a 32-bit fixed-length instruction set. It takes one instruction word, the value of the source register and the incoming summary-overflow bit. In the same cycle it decodes the register fields and the 16-bit immediate. It sign-extends the immediate and adds it to the source value. It then produces the sum, the unsigned carry-out and a four-bit condition field. A mode input sets the width of the carry and of the compare-to-zero: 32 bits or 64 bits.

The primary opcode alone decides whether the condition field is written. Opcode 12 updates only the destination register and the carry bit. Opcode 13 also updates condition field 0. Any other opcode raises an illegal flag, and no write-enable is set. The source register index comes out combinationally so that a register file can supply the operand in the same cycle. All results are registered and appear one clock after the instruction is presented.

Top module: `imm_carry_add_unit`

## Requirements
- R1: Fields are numbered from the instruction MSB: bits 31:26 are the opcode, 25:21 the destination index (output registered as `dst_idx`), 20:16 the source index (output combinationally as `src_sel`), and 15:0 the immediate. A source index of 0 gets no literal-zero substitution: `src_val` is always added as given.
- R2: The immediate is sign-extended to the operand width before the add, so 0xFFFF adds all ones.
- R3: With `wide_mode`=0, the result is the 32-bit sum zero-extended to 64 bits. `carry` is 1 exactly when that sum is unsigned-less-than `src_val[31:0]`.
- R4: With `wide_mode`=1, the result is the 64-bit sum and `carry` is the carry out of bit 63.
- R5: `cr0` is {LT, GT, EQ, SO} from bit 3 down. Exactly one of LT, GT and EQ is set, from a signed compare of the result against zero. In 32-bit mode the compare uses the sign-extended low 32 bits; in 64-bit mode it uses all 64 bits.
- R6: `cr0[0]` is a copy of the `xer_so` presented with the instruction.
- R7: Opcodes 12 and 13 both set `gpr_we` and `ca_we`. Only opcode 13 sets `cr0_we`.
- R8: Any other opcode sets `illegal` and clears `gpr_we`, `ca_we` and `cr0_we`.
- R9: Outputs are registered: a valid instruction at one rising edge gives `out_valid`=1 after that edge. Without a valid instruction, `out_valid`, `illegal` and every write-enable are 0, and all outputs are 0 after reset.
- R10: In record form with an immediate of −1, EQ is set only when the source value (at the active width) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| insn | input | 32 | Instruction word |
| src_val | input | 64 | Source register value |
| xer_so | input | 1 | Incoming summary-overflow bit |
| wide_mode | input | 1 | 1 selects 64-bit carry and compare |
| src_sel | output | 5 | Source register index (combinational) |
| out_valid | output | 1 | Result valid |
| dst_idx | output | 5 | Destination register index |
| result | output | 64 | Sum to write back |
| carry | output | 1 | New carry bit value |
| cr0 | output | 4 | {LT, GT, EQ, SO} |
| gpr_we | output | 1 | Destination register write-enable |
| ca_we | output | 1 | Carry bit write-enable |
| cr0_we | output | 1 | Condition field 0 write-enable |
| illegal | output | 1 | Unsupported opcode |

## Verification
`src_sel` is combinational, so the driver checks it a nanosecond after it applies the word. Every other output is due exactly one rising edge after the instruction is presented. The driver applies stimulus on a falling edge and pushes the expected result into a queue. The monitor samples on the next falling edge, when `out_valid` has just risen, pops the entry and compares it. Idle cycles between instructions are checked the same way, for cleared enables, so an item that arrives early, late or twice is caught.

// File: rtl/imm_carry_add_unit.sv
module imm_carry_add_unit #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int IMMW   = 16,
  parameter logic [5:0] OP_PLAIN  = 6'd12,
  parameter logic [5:0] OP_RECORD = 6'd13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_val,
  input  logic            xer_so,
  input  logic            wide_mode,
  output logic [4:0]      src_sel,
  output logic            out_valid,
  output logic [4:0]      dst_idx,
  output logic [XLEN-1:0] result,
  output logic            carry,
  output logic [3:0]      cr0,
  output logic            gpr_we,
  output logic            ca_we,
  output logic            cr0_we,
  output logic            illegal
);
  localparam int UPPER = XLEN - NARROW;

  logic [5:0]      opcd;
  logic [XLEN-1:0] imm_x;
  logic [XLEN:0]   sum_w;
  logic [NARROW:0] sum_n;
  logic [XLEN-1:0] res_c;
  logic [XLEN-1:0] cmp_v;
  logic            carry_c, is_plain, is_rec, known;
  logic            lt_c, gt_c, eq_c;

  assign opcd    = insn[31:26];
  assign src_sel = insn[20:16];
  assign imm_x   = {{(XLEN-IMMW){insn[IMMW-1]}}, insn[IMMW-1:0]};

  assign sum_w = {1'b0, src_val} + {1'b0, imm_x};
  assign sum_n = {1'b0, src_val[NARROW-1:0]} + {1'b0, imm_x[NARROW-1:0]};

  assign res_c   = wide_mode ? sum_w[XLEN-1:0] : {{UPPER{1'b0}}, sum_n[NARROW-1:0]};
  assign carry_c = wide_mode ? sum_w[XLEN] : sum_n[NARROW];
  assign cmp_v   = wide_mode ? sum_w[XLEN-1:0]
                             : {{UPPER{sum_n[NARROW-1]}}, sum_n[NARROW-1:0]};

  assign eq_c = (cmp_v == '0);
  assign lt_c = cmp_v[XLEN-1];
  assign gt_c = !lt_c && !eq_c;

  assign is_plain = (opcd == OP_PLAIN);
  assign is_rec   = (opcd == OP_RECORD);
  assign known    = is_plain || is_rec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst_idx   <= '0;
      result    <= '0;
      carry     <= 1'b0;
      cr0       <= '0;
      gpr_we    <= 1'b0;
      ca_we     <= 1'b0;
      cr0_we    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      gpr_we    <= in_valid && known;
      ca_we     <= in_valid && known;
      cr0_we    <= in_valid && is_rec;
      illegal   <= in_valid && !known;
      if (in_valid) begin
        dst_idx <= insn[25:21];
        result  <= res_c;
        carry   <= carry_c;
        cr0     <= {lt_c, gt_c, eq_c, xer_so};
      end
    end
  end
endmodule

module imm_carry_add_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     insn,
  input logic            xer_so,
  input logic            wide_mode,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic [3:0]      cr0,
  input logic            gpr_we,
  input logic            ca_we,
  input logic            cr0_we,
  input logic            illegal
);
  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cr0[3:1]) == 1);
  p_eq_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide_mode |=> cr0[1] == (result[31:0] == 32'd0));
  p_so_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> cr0[0] == $past(xer_so));
  p_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide_mode |=> result[XLEN-1:32] == '0);
  p_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && insn[31:26] == 6'd13 |=> cr0_we && gpr_we && ca_we);
  p_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && insn[31:26] == 6'd12 |=> !cr0_we && gpr_we && ca_we);
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !gpr_we && !ca_we && !cr0_we && out_valid);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !gpr_we && !ca_we && !cr0_we && !illegal);
endmodule

bind imm_carry_add_unit imm_carry_add_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
  .xer_so(xer_so), .wide_mode(wide_mode), .out_valid(out_valid),
  .result(result), .cr0(cr0), .gpr_we(gpr_we), .ca_we(ca_we),
  .cr0_we(cr0_we), .illegal(illegal)
);

// File: tb/imm_carry_add_unit_tb_top.sv
`timescale 1ns/1ps
module imm_carry_add_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_val = '0;
  logic        xer_so = 1'b0;
  logic        wide_mode = 1'b0;
  logic [4:0]  src_sel, dst_idx;
  logic        out_valid, carry, gpr_we, ca_we, cr0_we, illegal;
  logic [63:0] result;
  logic [3:0]  cr0;

  int checks = 0;
  int errors = 0;
  logic [77:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  imm_carry_add_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .src_val(src_val), .xer_so(xer_so), .wide_mode(wide_mode),
    .src_sel(src_sel), .out_valid(out_valid), .dst_idx(dst_idx),
    .result(result), .carry(carry), .cr0(cr0), .gpr_we(gpr_we),
    .ca_we(ca_we), .cr0_we(cr0_we), .illegal(illegal)
  );

  function automatic logic [77:0] model(input logic [31:0] w, input logic [63:0] a,
                                        input logic so, input logic wide);
    logic [5:0]  op;
    logic [63:0] i, r;
    logic [31:0] r32;
    logic        c, lt, gt, eq, leg;
    op = w[31:26];
    i  = 64'($signed(w[15:0]));
    if (wide) begin
      {c, r} = {1'b0, a} + {1'b0, i};
      lt = $signed(r) < 0;
      eq = $signed(r) == 0;
    end else begin
      r32 = a[31:0] + i[31:0];
      c   = r32 < a[31:0];
      r   = {32'd0, r32};
      lt  = $signed(r32) < 0;
      eq  = $signed(r32) == 0;
    end
    gt  = !lt && !eq;
    leg = (op == 6'd12) || (op == 6'd13);
    return {!leg, leg, leg, op == 6'd13, w[25:21], r, c, lt, gt, eq, so};
  endfunction

  task automatic issue(input logic [5:0] op, input logic [4:0] rd, input logic [4:0] ra,
                       input logic [15:0] imm, input logic [63:0] a,
                       input logic so, input logic wide, input string tag);
    @(negedge clk);
    insn      = {op, rd, ra, imm};
    src_val   = a;
    xer_so    = so;
    wide_mode = wide;
    in_valid  = 1'b1;
    exp_q.push_back(model(insn, a, so, wide));
    tag_q.push_back(tag);
    #1;
    checks++;
    if (src_sel !== ra) begin
      errors++;
      $display("FAIL R1 src_sel actual=%0d expected=%0d", src_sel, ra);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    insn     = {6'd13, 26'h3FFFFFF};
  endtask

  initial begin : monitor
    logic [77:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        checks++;
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9 unexpected result actual=1 expected=0");
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({illegal, gpr_we, ca_we, cr0_we} !== e[77:74] ||
                (!e[77] && {dst_idx, result, carry, cr0} !== e[73:0])) begin
              errors++;
              $display("FAIL %s actual=%h expected=%h", t,
                       {illegal, gpr_we, ca_we, cr0_we, dst_idx, result, carry, cr0}, e);
            end
          end
        end else if ({gpr_we, ca_we, cr0_we, illegal} !== 4'b0 || exp_q.size() != 0) begin
          errors++;
          $display("FAIL R9 idle enables actual=%b expected=0000 pending=%0d",
                   {gpr_we, ca_we, cr0_we, illegal}, exp_q.size());
        end
      end
    end
  end

  initial begin : watchdog
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, gpr_we, ca_we, cr0_we, illegal, result, cr0} !== '0) begin
      errors++;
      $display("FAIL R9 reset state actual=%h expected=0",
               {out_valid, gpr_we, ca_we, cr0_we, illegal, result, cr0});
    end
    rst_n = 1'b1;
    issue(6'd12, 5'd3, 5'd4, 16'd3, 64'd5, 1'b0, 1'b0, "R3 R7 plain small");
    issue(6'd12, 5'd7, 5'd8, 16'd1, 64'hFFFF_FFFF, 1'b0, 1'b0, "R3 wrap carry");
    issue(6'd13, 5'd1, 5'd2, 16'hFFFF, 64'd1, 1'b0, 1'b0, "R10 decrement to zero");
    issue(6'd13, 5'd1, 5'd2, 16'hFFFF, 64'd2, 1'b0, 1'b0, "R10 decrement to one");
    issue(6'd13, 5'd1, 5'd2, 16'hFFFF, 64'd0, 1'b0, 1'b0, "R10 R5 decrement below zero");
    idle();
    issue(6'd13, 5'd9, 5'd9, 16'hFFFF, 64'd0, 1'b0, 1'b1, "R4 R2 all ones wide");
    issue(6'd13, 5'd9, 5'd9, 16'hFFFF, 64'h1_0000_0000, 1'b0, 1'b1, "R4 R5 wide borrow");
    issue(6'd13, 5'd9, 5'd9, 16'hFFFF, 64'h1_0000_0000, 1'b0, 1'b0, "R5 R3 narrow view");
    issue(6'd13, 5'd9, 5'd9, 16'd1, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, "R5 wide sign flip");
    issue(6'd13, 5'd9, 5'd9, 16'hFFFF, 64'h1_0000_0001, 1'b0, 1'b1, "R10 wide not one");
    issue(6'd13, 5'd0, 5'd0, 16'h8000, 64'd5, 1'b1, 1'b0, "R6 R2 so copy negative imm");
    issue(6'd12, 5'd31, 5'd0, 16'h7FFF, 64'h1234, 1'b1, 1'b1, "R1 field decode source zero");
    idle();
    idle();
    issue(6'd14, 5'd5, 5'd6, 16'd1, 64'd1, 1'b0, 1'b0, "R8 opcode 14");
    issue(6'd0, 5'd5, 5'd6, 16'd1, 64'd1, 1'b1, 1'b1, "R8 opcode 0");
    for (int k = 0; k < 60; k++) begin
      logic [5:0] op;
      op = (k % 7 == 6) ? 6'($urandom_range(0, 63)) : (k[0] ? 6'd13 : 6'd12);
      issue(op, 5'($urandom), 5'($urandom), 16'($urandom),
            {$urandom, $urandom}, 1'($urandom), 1'($urandom), "R5 R7 mixed stream");
      if (k % 9 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule